// File: doc/BRIEF.md
# Interleaved Reed-Solomon Two-Symbol Frame Corrector

This block sits behind the deserializer of a 4.8 Gb/s optical link. Each cycle it can accept one 120-bit frame that carries two interleaved Reed-Solomon codewords. Each codeword has fifteen 4-bit symbols, eleven of them data and four of them check. The block splits the frame into its two codewords and decodes each one independently. A codeword with at most two bad symbols is corrected. The 88 protected bits then come out one clock later, together with a two-bit status for each codeword. Because the codewords alternate nibble by nibble, any nibble-aligned 16-bit burst lands as at most two bad symbols in each codeword, so the burst can always be repaired.

The decode for each codeword runs in parallel combinational logic:
- syndrome evaluation;
- a closed-form solution of the error-locator polynomial;
- a parallel test of all fifteen positions for locator roots;
- Forney magnitude computation.

The only register is at the output, so the decoder adds one 25 ns cycle of latency. When a codeword holds more errors than the code can fix, it is flagged and its data is passed on exactly as received.

Top module: `rs_ileave_dec`

## Requirements
- R1: Frame nibble k (bits 4k+3..4k, k = 0..29) is symbol k/2 of codeword A when k is even and symbol (k-1)/2 of codeword B when k is odd. Symbol i is the coefficient of x^i. Status bit 0 belongs to codeword A and status bit 1 to codeword B.
- R2: Symbols are elements of GF(16) built on x^4+x+1, with alpha = 0x2. A codeword is valid when c(alpha^j) = 0 for j = 1..4. Symbols 4..14 carry data, and data_o equals the corrected frame bits 119..32.
- R3: A codeword whose four syndromes are all zero is output unchanged, with fixed and fail both 0.
- R4: A single wrong symbol at any of the 15 positions, check positions included, is corrected and sets that codeword's fixed bit.
- R5: Two wrong symbols at any two positions of one codeword are corrected and set its fixed bit.
- R6: Any nibble-aligned 16-bit burst anywhere in the frame is fully corrected.
- R7: A codeword lying at distance more than two from every valid codeword sets fail, clears fixed, and passes its received symbols through unchanged. This does not affect the other codeword, and fixed and fail are never both set.
- R8: The outputs for a frame sampled with frame_vld_i high appear after the next rising clock edge. data_vld_o is frame_vld_i delayed by one cycle.
- R9: While frame_vld_i is low, data_o, fixed_o and fail_o keep their values.
- R10: rst_n low clears all outputs asynchronously. Release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld_i | input | 1 | frame_i holds a frame this cycle |
| frame_i | input | 120 | Received frame, two interleaved codewords |
| data_vld_o | output | 1 | Registered outputs belong to a new frame |
| data_o | output | 88 | Corrected protected bits |
| fixed_o | output | 2 | Per codeword: one or two symbols were corrected |
| fail_o | output | 2 | Per codeword: uncorrectable, data passed through |

## Verification
The hardest situation to reach is a codeword beyond the correcting radius. Roughly a third of such words lie within distance two of some other valid codeword and are legitimately "corrected" to it. The remainder must be flagged, and which case applies cannot be predicted from the injected pattern. The bench therefore injects three-symbol errors into encoded codewords and decides the expected outcome with its own bounded-distance search over all one- and two-symbol error patterns. This drives both the miscorrection branch and the degenerate-locator fail branch from the frame input alone.

// File: rtl/rs_gf_pkg.sv
package rs_gf_pkg;

  localparam int SYM_W = 4;
  localparam int N_SYM = 15;
  localparam int K_SYM = 11;
  localparam int N_CHK = N_SYM - K_SYM;
  localparam int CW_W  = N_SYM * SYM_W;
  localparam logic [SYM_W:0] PRIM = 5'b10011;

  typedef logic [SYM_W-1:0] sym_t;

  typedef struct packed {
    logic fixed;
    logic fail;
  } cw_stat_t;

  // shift-and-add product reduced by the field polynomial
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[SYM_W-1] ? (sym_t'(sh << 1) ^ PRIM[SYM_W-1:0]) : sym_t'(sh << 1);
    end
    return acc;
  endfunction

  // a^(2^m - 2); zero maps to zero
  function automatic sym_t gf_inv(sym_t a);
    sym_t r;
    r = sym_t'(1);
    for (int i = 0; i < N_SYM - 1; i++) r = gf_mul(r, a);
    return r;
  endfunction

  function automatic sym_t gf_pow_alpha(int e);
    sym_t r;
    int   em;
    r  = sym_t'(1);
    em = e % N_SYM;
    for (int i = 0; i < N_SYM; i++) begin
      if (i < em) r = gf_mul(r, sym_t'(2));
    end
    return r;
  endfunction

endpackage

// File: rtl/rs_syndrome.sv
module rs_syndrome
  import rs_gf_pkg::*;
#(
  parameter int NS = N_SYM,
  parameter int NR = N_CHK
) (
  input  logic [NS*SYM_W-1:0] cw_i,
  output sym_t [NR-1:0]       synd_o
);

  for (genvar j = 0; j < NR; j++) begin : g_syn
    localparam sym_t ROOT = gf_pow_alpha(j + 1);
    sym_t acc;
    // Horner evaluation from the highest-order symbol down
    always_comb begin
      acc = '0;
      for (int i = NS - 1; i >= 0; i--) begin
        acc = gf_mul(acc, ROOT) ^ cw_i[i*SYM_W +: SYM_W];
      end
    end
    assign synd_o[j] = acc;
  end

endmodule

// File: rtl/rs_locator.sv
module rs_locator
  import rs_gf_pkg::*;
(
  input  sym_t [N_CHK-1:0] synd_i,
  output sym_t             lam1_o,
  output sym_t             lam2_o,
  output logic [1:0]       deg_o,
  output logic             bad_o
);

  sym_t s1, s2, s3, s4;
  sym_t det, num1, num2, det_inv, s1_inv;

  assign s1 = synd_i[0];
  assign s2 = synd_i[1];
  assign s3 = synd_i[2];
  assign s4 = synd_i[3];

  assign det     = gf_mul(s2, s2) ^ gf_mul(s1, s3);
  assign num1    = gf_mul(s2, s3) ^ gf_mul(s1, s4);
  assign num2    = gf_mul(s2, s4) ^ gf_mul(s3, s3);
  assign det_inv = gf_inv(det);
  assign s1_inv  = gf_inv(s1);

  always_comb begin
    lam1_o = '0;
    lam2_o = '0;
    deg_o  = 2'd0;
    bad_o  = 1'b0;
    if (det != '0) begin
      lam1_o = gf_mul(num1, det_inv);
      lam2_o = gf_mul(num2, det_inv);
      deg_o  = 2'd2;
      bad_o  = (lam2_o == '0);
    end else if (s1 != '0) begin
      // singular system: try a lone error at X = S2/S1
      lam1_o = gf_mul(s2, s1_inv);
      deg_o  = 2'd1;
      bad_o  = (s2 == '0) || (gf_mul(s1, s4) != gf_mul(s2, s3));
    end else begin
      bad_o  = 1'b1;
    end
  end

endmodule

// File: rtl/rs_chien_forney.sv
module rs_chien_forney
  import rs_gf_pkg::*;
#(
  parameter int NS = N_SYM
) (
  input  sym_t [N_CHK-1:0]    synd_i,
  input  sym_t                lam1_i,
  input  sym_t                lam2_i,
  output logic [NS*SYM_W-1:0] err_o,
  output logic [NS-1:0]       root_o
);

  sym_t omega1;
  sym_t lam1_inv;

  // omega(x) = S1 + (S2 + S1*L1) x ; locator derivative equals L1
  assign omega1   = synd_i[1] ^ gf_mul(synd_i[0], lam1_i);
  assign lam1_inv = gf_inv(lam1_i);

  for (genvar p = 0; p < NS; p++) begin : g_pos
    localparam sym_t XINV = gf_pow_alpha((NS - p) % NS);
    localparam sym_t XINV2 = gf_mul(XINV, XINV);
    sym_t loc_val;
    sym_t mag;
    always_comb begin
      loc_val = sym_t'(1) ^ gf_mul(lam1_i, XINV) ^ gf_mul(lam2_i, XINV2);
      mag     = gf_mul(synd_i[0] ^ gf_mul(omega1, XINV), lam1_inv);
    end
    assign root_o[p] = (loc_val == '0);
    assign err_o[p*SYM_W +: SYM_W] = root_o[p] ? mag : '0;
  end

endmodule

// File: rtl/rs_cw_decoder.sv
module rs_cw_decoder
  import rs_gf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] cw_i,
  output logic [CW_W-1:0] cw_o,
  output cw_stat_t        stat_o
);

  localparam int CNT_W = $clog2(N_SYM + 1);

  sym_t [N_CHK-1:0]   synd;
  sym_t               lam1, lam2;
  logic [1:0]         deg;
  logic               bad;
  logic [N_SYM-1:0]   root;
  logic [CW_W-1:0]    err;
  logic [CNT_W-1:0]   nroot;
  logic               nz;
  logic               miss;

  rs_syndrome #(.NS(N_SYM), .NR(N_CHK)) u_syn (
    .cw_i   (cw_i),
    .synd_o (synd)
  );

  rs_locator u_loc (
    .synd_i (synd),
    .lam1_o (lam1),
    .lam2_o (lam2),
    .deg_o  (deg),
    .bad_o  (bad)
  );

  rs_chien_forney #(.NS(N_SYM)) u_cf (
    .synd_i (synd),
    .lam1_i (lam1),
    .lam2_i (lam2),
    .err_o  (err),
    .root_o (root)
  );

  always_comb begin
    nroot = '0;
    for (int i = 0; i < N_SYM; i++) nroot = nroot + CNT_W'(root[i]);
  end

  assign nz   = |synd;
  assign miss = bad | (nroot != CNT_W'(deg));

  assign stat_o.fail  = nz & miss;
  assign stat_o.fixed = nz & ~miss;
  assign cw_o         = stat_o.fail ? cw_i : (cw_i ^ err);

  function automatic int nib_diff(logic [CW_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < N_SYM; i++) begin
      if (v[i*SYM_W +: SYM_W] != '0) n++;
    end
    return n;
  endfunction

  // R3
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (synd == '0) |-> (cw_o == cw_i));

  // R5
  fix_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o.fixed |-> (nib_diff(cw_o ^ cw_i) >= 1 && nib_diff(cw_o ^ cw_i) <= 2));

endmodule

// File: rtl/rs_ileave_dec.sv
module rs_ileave_dec
  import rs_gf_pkg::*;
#(
  parameter int N_CW = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_vld_i,
  input  logic [N_CW*CW_W-1:0]        frame_i,
  output logic                        data_vld_o,
  output logic [N_CW*K_SYM*SYM_W-1:0] data_o,
  output logic [N_CW-1:0]             fixed_o,
  output logic [N_CW-1:0]             fail_o
);

  localparam int FRAME_W  = N_CW * CW_W;
  localparam int DATA_W   = N_CW * K_SYM * SYM_W;
  localparam int CHK_BITS = FRAME_W - DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [N_CW-1:0][CW_W-1:0] cw_in, cw_out;
  cw_stat_t [N_CW-1:0]       stat;
  logic [FRAME_W-1:0]        corr_frame;
  logic [N_CW-1:0]           fix_w, fail_w;

  for (genvar c = 0; c < N_CW; c++) begin : g_cw
    for (genvar s = 0; s < N_SYM; s++) begin : g_sym
      assign cw_in[c][s*SYM_W +: SYM_W]               = frame_i[(s*N_CW+c)*SYM_W +: SYM_W];
      assign corr_frame[(s*N_CW+c)*SYM_W +: SYM_W]    = cw_out[c][s*SYM_W +: SYM_W];
    end
    rs_cw_decoder u_dec (
      .clk    (clk),
      .rst_n  (rst_q),
      .cw_i   (cw_in[c]),
      .cw_o   (cw_out[c]),
      .stat_o (stat[c])
    );
    assign fix_w[c]  = stat[c].fixed;
    assign fail_w[c] = stat[c].fail;
  end

  // next state
  logic              vld_d;
  logic [DATA_W-1:0] data_d;
  logic [N_CW-1:0]   fixed_d, fail_d;

  always_comb begin
    vld_d   = frame_vld_i;
    data_d  = data_o;
    fixed_d = fixed_o;
    fail_d  = fail_o;
    if (frame_vld_i) begin
      data_d  = corr_frame[FRAME_W-1:CHK_BITS];
      fixed_d = fix_w;
      fail_d  = fail_w;
    end
  end

  // output register
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      data_vld_o <= 1'b0;
      data_o     <= '0;
      fixed_o    <= '0;
      fail_o     <= '0;
    end else begin
      data_vld_o <= vld_d;
      data_o     <= data_d;
      fixed_o    <= fixed_d;
      fail_o     <= fail_d;
    end
  end

  // R8
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_q)
    frame_vld_i |=> data_vld_o);

  // R8
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !frame_vld_i |=> !data_vld_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !frame_vld_i |=> ($stable(data_o) && $stable(fixed_o) && $stable(fail_o)));

  // R7
  excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (fixed_o & fail_o) == '0);

  // R3
  clean_frame_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (data_vld_o && fixed_o == '0 && fail_o == '0) |-> (data_o == $past(frame_i[FRAME_W-1:CHK_BITS])));

  for (genvar c = 0; c < N_CW; c++) begin : g_pass
    for (genvar s = 0; s < K_SYM; s++) begin : g_dsym
      // R7
      pass_chk: assert property (@(posedge clk) disable iff (!rst_q)
        (data_vld_o && fail_o[c]) |->
        (data_o[(s*N_CW+c)*SYM_W +: SYM_W] == $past(frame_i[((s+N_CHK)*N_CW+c)*SYM_W +: SYM_W])));
    end
  end

endmodule

// File: tb/sim_rs_ileave_dec.sv
module sim_rs_ileave_dec;

  logic         clk;
  logic         rst_n;
  logic         frame_vld_i;
  logic [119:0] frame_i;
  logic         data_vld_o;
  logic [87:0]  data_o;
  logic [1:0]   fixed_o;
  logic [1:0]   fail_o;

  int total = 0;
  int bad   = 0;
  int fails_seen = 0;

  logic [3:0] gexp [15];
  int         glog [16];
  logic [3:0] gen  [5];

  rs_ileave_dec u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_vld_i (frame_vld_i),
    .frame_i     (frame_i),
    .data_vld_o  (data_vld_o),
    .data_o      (data_o),
    .fixed_o     (fixed_o),
    .fail_o      (fail_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [87:0] act, input logic [87:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] bmul(logic [3:0] a, logic [3:0] b);
    if (a == 0 || b == 0) return 4'h0;
    return gexp[(glog[a] + glog[b]) % 15];
  endfunction

  function automatic logic [3:0] apow(int e);
    return gexp[e % 15];
  endfunction

  task automatic build_field();
    logic [3:0] v;
    v = 4'h1;
    for (int i = 0; i < 15; i++) begin
      gexp[i] = v;
      glog[v] = i;
      v = v[3] ? ({v[2:0], 1'b0} ^ 4'h3) : {v[2:0], 1'b0};
    end
    glog[0] = 0;
    // generator = product of (x + alpha^j), j = 1..4
    gen[0] = 4'h1;
    for (int i = 1; i < 5; i++) gen[i] = 4'h0;
    for (int j = 1; j <= 4; j++) begin
      for (int i = 4; i >= 1; i--) gen[i] = gen[i-1] ^ bmul(gen[i], apow(j));
      gen[0] = bmul(gen[0], apow(j));
    end
  endtask

  function automatic logic [59:0] encode(logic [43:0] msg);
    logic [59:0] cw;
    logic [3:0]  r [4];
    logic [3:0]  fb;
    cw = {msg, 16'h0};
    for (int i = 0; i < 4; i++) r[i] = 4'h0;
    for (int i = 14; i >= 4; i--) begin
      fb   = cw[i*4 +: 4] ^ r[3];
      r[3] = r[2] ^ bmul(fb, gen[3]);
      r[2] = r[1] ^ bmul(fb, gen[2]);
      r[1] = r[0] ^ bmul(fb, gen[1]);
      r[0] = bmul(fb, gen[0]);
    end
    for (int i = 0; i < 4; i++) cw[i*4 +: 4] = r[i];
    return cw;
  endfunction

  function automatic logic [119:0] weave(logic [59:0] a, logic [59:0] b);
    logic [119:0] f;
    for (int s = 0; s < 15; s++) begin
      f[(2*s)*4 +: 4]   = a[s*4 +: 4];
      f[(2*s+1)*4 +: 4] = b[s*4 +: 4];
    end
    return f;
  endfunction

  // bounded-distance reference: search all weight-1 and weight-2 patterns
  task automatic ref_cw(input logic [59:0] rx, output logic [59:0] fx,
                        output logic fixed, output logic fail);
    logic [3:0] sr [4];
    logic       found, ok;
    for (int j = 0; j < 4; j++) begin
      sr[j] = 4'h0;
      for (int i = 0; i < 15; i++) sr[j] = sr[j] ^ bmul(rx[i*4 +: 4], apow((j+1)*i));
    end
    fx = rx; fixed = 1'b0; fail = 1'b0;
    if ((sr[0] | sr[1] | sr[2] | sr[3]) == 4'h0) return;
    found = 1'b0;
    for (int i = 0; i < 15 && !found; i++)
      for (int e = 1; e < 16 && !found; e++) begin
        ok = 1'b1;
        for (int j = 0; j < 4; j++) if (bmul(4'(e), apow((j+1)*i)) != sr[j]) ok = 1'b0;
        if (ok) begin found = 1'b1; fx[i*4 +: 4] = rx[i*4 +: 4] ^ 4'(e); end
      end
    for (int i = 0; i < 15 && !found; i++)
      for (int k = i + 1; k < 15 && !found; k++)
        for (int e = 1; e < 16 && !found; e++)
          for (int f = 1; f < 16 && !found; f++) begin
            ok = 1'b1;
            for (int j = 0; j < 4; j++)
              if ((bmul(4'(e), apow((j+1)*i)) ^ bmul(4'(f), apow((j+1)*k))) != sr[j]) ok = 1'b0;
            if (ok) begin
              found = 1'b1;
              fx[i*4 +: 4] = rx[i*4 +: 4] ^ 4'(e);
              fx[k*4 +: 4] = rx[k*4 +: 4] ^ 4'(f);
            end
          end
    fixed = found;
    fail  = !found;
  endtask

  task automatic send(input logic [119:0] f);
    @(negedge clk);
    frame_vld_i = 1'b1;
    frame_i     = f;
    @(negedge clk);
    frame_vld_i = 1'b0;
  endtask

  task automatic check_frame(input logic [119:0] f, input string req);
    logic [59:0]  a, b, fa, fb;
    logic         xa, xb, la, lb;
    logic [119:0] ef;
    for (int s = 0; s < 15; s++) begin
      a[s*4 +: 4] = f[(2*s)*4 +: 4];
      b[s*4 +: 4] = f[(2*s+1)*4 +: 4];
    end
    ref_cw(a, fa, xa, la);
    ref_cw(b, fb, xb, lb);
    ef = weave(fa, fb);
    if (la || lb) fails_seen++;
    send(f);
    chk({req, " R8 valid"}, 88'(data_vld_o), 88'd1);
    chk({req, " fixed"}, 88'(fixed_o), 88'({xb, xa}));
    chk({req, " fail"}, 88'(fail_o), 88'({lb, la}));
    chk({req, " data"}, data_o, ef[119:32]);
  endtask

  function automatic logic [43:0] rnd_msg();
    return 44'({$urandom(), $urandom()});
  endfunction

  function automatic logic [3:0] rnd_err();
    return 4'($urandom_range(1, 15));
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    frame_vld_i = 1'b0;
    frame_i = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 88'(data_vld_o), 88'd0);
    chk("R10 reset data", data_o, 88'd0);
    chk("R10 reset status", 88'({fixed_o, fail_o}), 88'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_clean();
    for (int n = 0; n < 3; n++) begin
      logic [43:0] ma, mb;
      logic [87:0] ed;
      ma = rnd_msg(); mb = rnd_msg();
      for (int s = 0; s < 11; s++) begin
        ed[(2*s)*4 +: 4]   = ma[s*4 +: 4];
        ed[(2*s+1)*4 +: 4] = mb[s*4 +: 4];
      end
      send(weave(encode(ma), encode(mb)));
      chk("R3 R2 clean data", data_o, ed);
      chk("R3 clean status", 88'({fixed_o, fail_o}), 88'd0);
    end
  endtask

  task automatic t_single();
    for (int p = 0; p < 15; p++) begin
      logic [59:0] a, b;
      a = encode(rnd_msg()); b = encode(rnd_msg());
      a[p*4 +: 4] ^= rnd_err();
      b[(14-p)*4 +: 4] ^= rnd_err();
      check_frame(weave(a, b), "R4 single");
      chk("R4 both fixed", 88'(fixed_o), 88'd3);
    end
  endtask

  task automatic t_interleave();
    logic [119:0] f;
    f = weave(encode(rnd_msg()), encode(rnd_msg()));
    f[5*4 +: 4] ^= 4'h9;
    check_frame(f, "R1 odd nibble");
    chk("R1 odd nibble to B", 88'(fixed_o), 88'd2);
    f = weave(encode(rnd_msg()), encode(rnd_msg()));
    f[12*4 +: 4] ^= 4'h6;
    check_frame(f, "R1 even nibble");
    chk("R1 even nibble to A", 88'(fixed_o), 88'd1);
  endtask

  task automatic t_double();
    int pa [5] = '{0, 3, 7, 13, 2};
    int pb [5] = '{14, 4, 8, 1, 11};
    for (int n = 0; n < 5; n++) begin
      logic [59:0] a, b;
      a = encode(rnd_msg()); b = encode(rnd_msg());
      a[pa[n]*4 +: 4] ^= rnd_err();
      a[pb[n]*4 +: 4] ^= rnd_err();
      b[pa[n]*4 +: 4] ^= rnd_err();
      b[((pb[n]+5)%15)*4 +: 4] ^= rnd_err();
      check_frame(weave(a, b), "R5 double");
      chk("R5 both fixed", 88'(fixed_o), 88'd3);
    end
  endtask

  task automatic t_burst();
    int offs [5] = '{0, 7, 13, 20, 26};
    for (int n = 0; n < 5; n++) begin
      logic [119:0] f, g;
      logic [15:0]  pat;
      f = weave(encode(rnd_msg()), encode(rnd_msg()));
      g = f;
      pat = 16'($urandom()) | 16'h8421;
      f[offs[n]*4 +: 16] ^= pat;
      send(f);
      chk("R6 burst data", data_o, g[119:32]);
      chk("R6 burst fail", 88'(fail_o), 88'd0);
    end
  endtask

  task automatic t_beyond();
    for (int n = 0; n < 8; n++) begin
      logic [59:0] a, b;
      a = encode(rnd_msg()); b = encode(rnd_msg());
      a[n*4 +: 4] ^= rnd_err();
      a[((n+5)%15)*4 +: 4] ^= rnd_err();
      a[((n+9)%15)*4 +: 4] ^= rnd_err();
      b[((n+3)%15)*4 +: 4] ^= rnd_err();
      check_frame(weave(a, b), "R7 beyond");
      chk("R7 exclusive", 88'(fixed_o & fail_o), 88'd0);
    end
    chk("R7 some uncorrectable seen", 88'(fails_seen > 0), 88'd1);
  endtask

  task automatic t_hold();
    logic [87:0] d0;
    logic [3:0]  s0;
    logic [59:0] a;
    a = encode(rnd_msg());
    a[6*4 +: 4] ^= 4'h3;
    send(weave(a, encode(rnd_msg())));
    d0 = data_o;
    s0 = {fixed_o, fail_o};
    frame_i = '1;
    repeat (3) @(negedge clk);
    chk("R8 valid drops", 88'(data_vld_o), 88'd0);
    chk("R9 data held", data_o, d0);
    chk("R9 status held", 88'({fixed_o, fail_o}), 88'(s0));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 async clear data", data_o, 88'd0);
    chk("R10 async clear valid", 88'(data_vld_o), 88'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    build_field();
    t_reset();
    t_clean();
    t_single();
    t_interleave();
    t_double();
    t_burst();
    t_beyond();
    t_hold();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule